// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

A watchdog peripheral with two clock domains. Registers sit on a 32-bit write/read bus clocked by `pclk`. The counter runs on a separate oscillator clock, `oscClk`. Software loads a 12-bit period, restarts the elapsed count and sets the enable bit. The counter then measures overflow intervals of 2^PRE_W × (N + 1) oscillator cycles, where N is the period field. PRE_W defaults to 20, which gives 1024 × 1024 cycles per step.

The first interval that expires without service raises a level interrupt. If the next interval also expires with no service, the block raises a system reset request. That request holds until the block's own asynchronous reset. Software keeps the system alive by writing 1 to bit 0 of the service register. This clears the pending interrupt at once on the bus clock, restarts the elapsed count and discards the first overflow.

Writes to the control, period and counter registers reach the oscillator domain through toggle synchronizers. Software must therefore space writes to the same register by a few oscillator cycles. Programming a period of 1 gives a short path to reset, for use as a forced restart.

Top module: `wdog_top`

## Requirements
- R1: After `rstN` is low, `irqOut` and `rstReqOut` are 0 and the registers at byte offsets 0x00, 0x04 and 0x0C read 0.
- R2: The control register at offset 0x00 stores only bit 0 (enable, 1 = count). It reads back with bits [31:1] at 0.
- R3: The period register at offset 0x04 keeps only bits [31:20] as the 12-bit value N. Other written bits are dropped, so the register reads back as N in [31:20] with 0 elsewhere.
- R4: With enable set, the first overflow comes 2^PRE_W × (N + 1) oscillator cycles after the count restarts. It sets `irqOut` to 1, and bit 0 of offset 0x0C reads 1 while the interrupt is pending.
- R5: A second overflow with no service since the first sets `rstReqOut` to 1. The first overflow alone never does.
- R6: Once set, `rstReqOut` stays 1, unaffected by bus writes including service, until `rstN` is asserted.
- R7: Writing a value with bit 0 = 1 to offset 0x0C clears `irqOut` on the next `pclk` edge, with no synchronizer delay. It also restarts the elapsed count and forgets the first overflow, so periodic service prevents reset. Writing bit 0 = 0 there has no effect.
- R8: Any write to offset 0x08 restarts the elapsed count from zero.
- R9: Writing 0 to the enable bit freezes the count, so no further overflow or reset request follows.
- R10: With N = 1, `rstReqOut` rises 4 × 2^PRE_W oscillator cycles after enabling, and the interrupt comes halfway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register bus clock |
| oscClk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWr | input | 1 | Write strobe, one `pclk` cycle per write |
| busAddr | input | 4 | Byte offset (0x0, 0x4, 0x8, 0xC); unaligned writes are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Level interrupt, first overflow pending |
| rstReqOut | output | 1 | System reset request, second overflow |

## Verification
The counter is run with periods of 1, 2 and 5. The prescaler is shortened so that interrupt and reset can be timed against a window around the expected instant, which separates the first overflow from the second and confirms the (N + 1) scaling. Periodic service, disabling after the interrupt, restarting the count halfway, and letting two intervals pass all start from the same state. Only one of these ends in a reset request, which separates keep-alive, freeze and restart from a true double expiry. Register patterns with all bits set show which bits are kept. A service write with bit 0 clear shows that the write is decoded on its data bit.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int DATA_W = 32;

  // word index of each register (byte offset / 4)
  localparam logic [1:0] CTL_IDX = 2'd0;
  localparam logic [1:0] PER_IDX = 2'd1;
  localparam logic [1:0] CNT_IDX = 2'd2;
  localparam logic [1:0] SVC_IDX = 2'd3;

  // strobes from the bus side toward the counter
  typedef struct packed {
    logic loadEn;
    logic loadPer;
    logic clrCount;
  } xingStrobe_t;

  localparam int XING_N = $bits(xingStrobe_t);
endpackage

// File: rtl/wdog_pulse_sync.sv
`timescale 1ns/1ps
module wdog_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic srcClk,
  input  logic dstClk,
  input  logic rstN,
  input  logic srcPulse,
  output logic dstPulse
);
  logic srcTog;
  logic [STAGES:0] dstShift;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) srcTog <= 1'b0;
    else if (srcPulse) srcTog <= ~srcTog;
  end

  always_ff @(posedge dstClk or negedge rstN) begin
    if (!rstN) dstShift <= '0;
    else dstShift <= {dstShift[STAGES-1:0], srcTog};
  end

  assign dstPulse = dstShift[STAGES] ^ dstShift[STAGES-1];
endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic              pclk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [3:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              ovfEvent,
  output xingStrobe_t       stb,
  output logic              enVal,
  output logic [PER_W-1:0]  perVal,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - PER_W;

  logic aligned, wrCtl, wrPer, wrCnt, svcWr;
  logic irqPend;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrCtl   = busWr && aligned && (busAddr[3:2] == CTL_IDX);
  assign wrPer   = busWr && aligned && (busAddr[3:2] == PER_IDX);
  assign wrCnt   = busWr && aligned && (busAddr[3:2] == CNT_IDX);
  assign svcWr   = busWr && aligned && (busAddr[3:2] == SVC_IDX) && busWdata[0];

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      enVal   <= 1'b0;
      perVal  <= '0;
      irqPend <= 1'b0;
    end else begin
      if (wrCtl) enVal <= busWdata[0];
      if (wrPer) perVal <= busWdata[DATA_W-1 -: PER_W];
      if (svcWr) irqPend <= 1'b0;
      else if (ovfEvent) irqPend <= 1'b1;
    end
  end

  always_comb begin
    stb.loadEn   = wrCtl;
    stb.loadPer  = wrPer;
    stb.clrCount = wrCnt | svcWr;
  end

  always_comb begin
    unique case (busAddr[3:2])
      CTL_IDX: busRdata = {{(DATA_W-1){1'b0}}, enVal};
      PER_IDX: busRdata = {perVal, {PAD_W{1'b0}}};
      CNT_IDX: busRdata = '0;
      default: busRdata = {{(DATA_W-1){1'b0}}, irqPend};
    endcase
  end

  assign irqOut = irqPend;

  // service acts on the very next bus edge
  assert_svc_clears_irq_R7: assert property (@(posedge pclk) disable iff (!rstN)
    svcWr |=> !irqOut);
  // interrupt only rises after an overflow event from the counter
  assert_irq_from_ovf_R4: assert property (@(posedge pclk) disable iff (!rstN)
    $rose(irqOut) |-> $past(ovfEvent));
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count
  import wdog_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int PER_W = 12
) (
  input  logic             oscClk,
  input  logic             rstN,
  input  xingStrobe_t      stb,
  input  logic             enVal,
  input  logic [PER_W-1:0] perVal,
  output logic             ovfPulse,
  output logic             rstReq
);
  logic             enReg;
  logic [PER_W-1:0] perReg;
  logic [PRE_W-1:0] pre;
  logic [PER_W-1:0] ival;
  logic             stage;
  logic             preWrap;

  assign preWrap = (pre == {PRE_W{1'b1}});

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      perReg   <= '0;
      pre      <= '0;
      ival     <= '0;
      stage    <= 1'b0;
      rstReq   <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      if (stb.loadEn)  enReg  <= enVal;
      if (stb.loadPer) perReg <= perVal;
      if (stb.clrCount) begin
        pre   <= '0;
        ival  <= '0;
        stage <= 1'b0;
      end else if (stb.loadPer) begin
        pre  <= '0;
        ival <= '0;
      end else if (enReg && !rstReq) begin
        pre <= pre + 1'b1;
        if (preWrap) begin
          if (ival == perReg) begin
            ival     <= '0;
            ovfPulse <= 1'b1;
            if (stage) rstReq <= 1'b1;
            else       stage  <= 1'b1;
          end else begin
            ival <= ival + 1'b1;
          end
        end
      end
    end
  end

  assert_rst_sticky_R6: assert property (@(posedge oscClk) disable iff (!rstN)
    rstReq |=> rstReq);
  assert_rst_needs_stage_R5: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(rstReq) |-> $past(stage));
  assert_hold_when_off_R9: assert property (@(posedge oscClk) disable iff (!rstN)
    (!enReg && !stb.clrCount && !stb.loadPer) |=> $stable(pre));
  assert_ival_range_R4: assert property (@(posedge oscClk) disable iff (!rstN)
    ival <= perReg);
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_W       = 20,
  parameter int PER_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic        pclk,
  input  logic        oscClk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqOut,
  output logic        rstReqOut
);
  xingStrobe_t      stbBus, stbOsc;
  logic [XING_N-1:0] stbBusVec, stbOscVec;
  logic             enVal, ovfOsc, ovfBus;
  logic [PER_W-1:0] perVal;

  wdog_ctrl #(.PER_W(PER_W)) uCtrl (
    .pclk(pclk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ovfEvent(ovfBus),
    .stb(stbBus), .enVal(enVal), .perVal(perVal), .irqOut(irqOut)
  );

  assign stbBusVec = stbBus;

  for (genvar i = 0; i < XING_N; i++) begin : gXing
    wdog_pulse_sync #(.STAGES(SYNC_STAGES)) uSync (
      .srcClk(pclk), .dstClk(oscClk), .rstN(rstN),
      .srcPulse(stbBusVec[i]), .dstPulse(stbOscVec[i])
    );
  end

  assign stbOsc = stbOscVec;

  wdog_pulse_sync #(.STAGES(SYNC_STAGES)) uOvfSync (
    .srcClk(oscClk), .dstClk(pclk), .rstN(rstN),
    .srcPulse(ovfOsc), .dstPulse(ovfBus)
  );

  wdog_count #(.PRE_W(PRE_W), .PER_W(PER_W)) uCount (
    .oscClk(oscClk), .rstN(rstN), .stb(stbOsc), .enVal(enVal),
    .perVal(perVal), .ovfPulse(ovfOsc), .rstReq(rstReqOut)
  );
endmodule

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  localparam int PRE_W = 6;
  localparam real OSC_NS = 16.0;

  logic pclk = 1'b0, oscClk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, rstReqOut;
  int total = 0, bad = 0;

  always #5 pclk = ~pclk;
  always #8 oscClk = ~oscClk;

  wdog_top #(.PRE_W(PRE_W)) dut (
    .pclk(pclk), .oscClk(oscClk), .rstN(rstN), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  function automatic real ivalNs(int n);
    return (2.0 ** PRE_W) * (n + 1) * OSC_NS;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge pclk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge pclk);
    busWr = 1'b0;
  endtask

  task automatic settle();
    #100;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge pclk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #40;
    rstN = 1'b1;
    #50;
  endtask

  task automatic startWd(int n);
    wr(4'h4, 32'(n) << 20); settle();
    wr(4'h8, 32'h0);        settle();
    wr(4'h0, 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    chk("R1 rstReq", {31'b0, rstReqOut}, 32'h0);
    rd(4'h0, d); chk("R1 ctl", d, 32'h0);
    rd(4'h4, d); chk("R1 per", d, 32'h0);
    rd(4'hC, d); chk("R1 svc", d, 32'h0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF); settle();
    rd(4'h4, d); chk("R3 period mask", d, 32'hFFF0_0000);
    wr(4'h0, 32'hFFFF_FFFE); settle();
    rd(4'h0, d); chk("R2 enable bit0 only", d, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF); settle();
    rd(4'h0, d); chk("R2 enable set", d, 32'h1);
    wr(4'h0, 32'h0); settle();
  endtask

  task automatic testServiceAndFreeze();
    real t = ivalNs(2);
    logic [31:0] d;
    startWd(2);
    #(t * 0.8); chk("R4 no irq early", {31'b0, irqOut}, 32'h0);
    #(t * 0.4); chk("R4 irq after interval", {31'b0, irqOut}, 32'h1);
    rd(4'hC, d); chk("R4 pending bit", d, 32'h1);
    chk("R5 no reset after first", {31'b0, rstReqOut}, 32'h0);
    wr(4'hC, 32'h1);
    chk("R7 irq cleared at once", {31'b0, irqOut}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      #(t * 0.8);
      wr(4'hC, 32'h1);
    end
    chk("R7 keep-alive no reset", {31'b0, rstReqOut}, 32'h0);
    chk("R7 keep-alive no irq", {31'b0, irqOut}, 32'h0);
    #(t * 1.2); chk("R7 irq after last service", {31'b0, irqOut}, 32'h1);
    wr(4'hC, 32'h0);
    chk("R7 bit0 clear ignored", {31'b0, irqOut}, 32'h1);
    settle();
    wr(4'h0, 32'h0);
    #(t * 1.5);
    chk("R9 disabled no reset", {31'b0, rstReqOut}, 32'h0);
    chk("R9 irq still pending", {31'b0, irqOut}, 32'h1);
    wr(4'hC, 32'h1); settle();
  endtask

  task automatic testDoubleOverflow();
    real t = ivalNs(2);
    startWd(2);
    #(t * 1.9);
    chk("R5 irq before second", {31'b0, irqOut}, 32'h1);
    chk("R5 no reset before second", {31'b0, rstReqOut}, 32'h0);
    #(t * 0.3); chk("R5 reset on second", {31'b0, rstReqOut}, 32'h1);
    #(t * 1.0); chk("R6 reset held", {31'b0, rstReqOut}, 32'h1);
    wr(4'hC, 32'h1); settle();
    wr(4'h0, 32'h0); settle();
    chk("R6 reset held after writes", {31'b0, rstReqOut}, 32'h1);
    doReset();
    chk("R6 cleared by rstN", {31'b0, rstReqOut}, 32'h0);
  endtask

  task automatic testCounterRestart();
    real t = ivalNs(2);
    startWd(2);
    #(t * 0.7);
    wr(4'h8, 32'h0);
    #(t * 0.7); chk("R8 restart delays irq", {31'b0, irqOut}, 32'h0);
    #(t * 0.6); chk("R8 irq after restart", {31'b0, irqOut}, 32'h1);
    doReset();
  endtask

  task automatic testPeriodOne();
    real t = ivalNs(1);
    startWd(1);
    #(t * 1.1); chk("R10 irq halfway", {31'b0, irqOut}, 32'h1);
    #(t * 0.7); chk("R10 no reset early", {31'b0, rstReqOut}, 32'h0);
    #(t * 0.4); chk("R10 reset after two", {31'b0, rstReqOut}, 32'h1);
    doReset();
  endtask

  task automatic testLongPeriod();
    real t = ivalNs(5);
    startWd(5);
    #(t * 0.9); chk("R4 N=5 no irq early", {31'b0, irqOut}, 32'h0);
    #(t * 0.2); chk("R4 N=5 irq", {31'b0, irqOut}, 32'h1);
    doReset();
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23;
    rstN = 1'b1;
    #50;
    testReset();
    testRegs();
    testServiceAndFreeze();
    testDoubleOverflow();
    testCounterRestart();
    testPeriodOne();
    testLongPeriod();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule